// File: doc/BRIEF.md
# Prioritised Interrupt Controller Core

This block collects up to 32 interrupt request lines and presents one interrupt line to a processor. Each line has a mode word on a simple register bus. The mode word picks level or edge sensing, the active polarity or edge direction, and a 3-bit priority. Software turns lines on with a write-one command word and off with another write-one command word. It clears captured edges with a third command word. It reads request status as one bit per line.

The core keeps a service stack of priorities. When the processor acknowledges the interrupt, the stack records the priority of the best enabled pending line. From then on the interrupt line is raised only for lines of strictly higher priority. A write of any value to the end-of-service word pops the stack, which lets lower-priority work interrupt again.

All bus accesses are single-cycle. Writes take effect at the clock edge. Read data follows the address combinationally while the write strobe is low.

Top module: `intc_core`

## Requirements
- R1: After synchronous active-low reset, every line is disabled, every mode word reads 0x40 (level, active high, priority 0), the service stack is empty and `irq` is low.
- R2: The mode word of line i lives at byte address 4*i. Bit 5 selects edge (1) or level (0). Bit 6 selects high/rising (1) or low/falling (0). Bits [2:0] hold the priority. A write sets all three fields, and every other bit reads 0.
- R3: A write to address 0x80 sets the enable of every line whose data bit is 1 and leaves the others unchanged. The enable vector reads back at 0x90.
- R4: A write to address 0x84 clears the enable of every line whose data bit is 1 and leaves the others unchanged.
- R5: Each input passes two synchronising flops. For a level line, the request bit equals (input == polarity). A change driven before clock edge k shows up after edge k+1.
- R6: An edge line captures the selected edge of its synchronised input. The capture is visible after the third edge from the change. It stays set after the input returns.
- R7: A write to 0x88 clears the captured request of each edge line whose data bit is 1. Level lines are not affected. An edge detected in the same cycle wins over the clear.
- R8: Address 0x84+8 = 0x8C reads the request bit of every line, whether enabled or not.
- R9: `irq` is high exactly when some enabled line has a request and its priority is above the top of the service stack, or the stack is empty.
- R10: `irq_ack` while `irq` is high pushes the highest priority among enabled requesting lines. `irq_ack` while `irq` is low has no effect.
- R11: Any write to 0x94 pops the service stack. On an empty stack it has no effect.
- R12: The command addresses 0x80, 0x84, 0x88, 0x94 and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | N_SRC | Raw interrupt request lines |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_ack | input | 1 | Processor acknowledge of `irq` |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The directed patterns are chosen to separate behaviours that are easy to confuse:

- A single level line raised and held shows the two-flop latency.
- A one-cycle pulse on a rising-edge line, and a high-to-low step on a falling-edge line, show that a capture persists after the input returns and that direction matters.
- A clear word that names both a level line and an edge line shows that only the edge capture is cleared.
- Nested acknowledges at two priorities, then end-of-service writes in turn, show strict-priority masking and the stack unwinding.
- An acknowledge while `irq` is low shows that no phantom push occurs.

A long pseudo-random phase then mixes input toggles, mode rewrites, enable changes, acknowledges and end-of-service writes. A behavioural model is compared every cycle on `irq` and on the read data.

// File: rtl/intc_pkg.sv
// Shared constants of the interrupt controller: register addresses and
// mode-word bit positions. Assumes byte addressing with 32-bit words.
package intc_pkg;
    localparam int unsigned BUS_AW   = 8;
    localparam int unsigned BUS_DW   = 32;
    localparam int unsigned MAX_SRC  = 32;
    localparam int unsigned MB_EDGE  = 5;
    localparam int unsigned MB_POL   = 6;

    localparam logic [BUS_AW-1:0] A_EN_SET  = 8'h80;
    localparam logic [BUS_AW-1:0] A_EN_CLR  = 8'h84;
    localparam logic [BUS_AW-1:0] A_REQ_CLR = 8'h88;
    localparam logic [BUS_AW-1:0] A_PEND    = 8'h8C;
    localparam logic [BUS_AW-1:0] A_EN_STAT = 8'h90;
    localparam logic [BUS_AW-1:0] A_EOI     = 8'h94;
endpackage

// File: rtl/intc_src_cell.sv
// One request line: two-flop synchroniser, mode word, edge capture and
// request output. Assumes mode writes and capture clears are one-cycle pulses.
module intc_src_cell #(
    parameter int unsigned PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_i,
    input  logic              mode_we,
    input  logic              wr_edge,
    input  logic              wr_pol,
    input  logic [PRIO_W-1:0] wr_prio,
    input  logic              req_clr,
    output logic              edge_o,
    output logic              pol_o,
    output logic [PRIO_W-1:0] prio_o,
    output logic              pend_o
);
    logic              s1_q, s2_q, s3_q;
    logic              edge_q, pol_q, cap_q;
    logic [PRIO_W-1:0] prio_q;
    logic              det;

    // Synchronise the raw line and keep one older sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= src_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Hold the mode word; reset to level, active high, priority zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= 1'b0;
            pol_q  <= 1'b1;
            prio_q <= '0;
        end else if (mode_we) begin
            edge_q <= wr_edge;
            pol_q  <= wr_pol;
            prio_q <= wr_prio;
        end
    end

    // Detect the selected edge on the synchronised input.
    always_comb begin
        det = edge_q && (pol_q ? (s2_q && !s3_q) : (!s2_q && s3_q));
    end

    // Capture edges until software clears them; a new edge beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
        end else if (!edge_q) begin
            cap_q <= 1'b0;
        end else begin
            cap_q <= (cap_q && !req_clr) || det;
        end
    end

    // Request output: capture for edge lines, polarity match for level lines.
    always_comb begin
        pend_o = edge_q ? cap_q : (s2_q == pol_q);
    end

    assign edge_o = edge_q;
    assign pol_o  = pol_q;
    assign prio_o = prio_q;
endmodule

// File: rtl/intc_prio_sel.sv
// Finds the highest priority among candidate lines. Purely combinational;
// assumes priorities arrive flattened, line i at bits [i*PRIO_W +: PRIO_W].
module intc_prio_sel #(
    parameter int unsigned N_SRC  = 32,
    parameter int unsigned PRIO_W = 3
) (
    input  logic [N_SRC-1:0]        cand,
    input  logic [N_SRC*PRIO_W-1:0] prio_flat,
    output logic                    any_o,
    output logic [PRIO_W-1:0]       best_o
);
    // Scan every line and keep the largest priority seen.
    always_comb begin
        any_o  = 1'b0;
        best_o = '0;
        for (int i = 0; i < int'(N_SRC); i++) begin
            if (cand[i] && (!any_o || prio_flat[i*PRIO_W +: PRIO_W] > best_o)) begin
                any_o  = 1'b1;
                best_o = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/intc_svc_stack.sv
// Stack of priorities in service. A pop is applied before a push in the same
// cycle. Assumes pushes only of priorities above the top, so the depth never
// exceeds the number of priority levels.
module intc_svc_stack #(
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned DEPTH  = 1 << PRIO_W,
    parameter int unsigned DW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic              busy_o,
    output logic [PRIO_W-1:0] top_o,
    output logic [DW-1:0]     depth_o
);
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PRIO_W-1:0] stk_q [DEPTH];
    logic [DW-1:0]     depth_q;
    logic [DW-1:0]     base;
    logic [DW-1:0]     top_idx;
    logic              pop_eff, push_eff;

    // Work out the effective pop and push for this cycle.
    always_comb begin
        pop_eff  = pop && (depth_q != '0);
        base     = depth_q - DW'(pop_eff);
        push_eff = push && (base < DW'(DEPTH));
        top_idx  = depth_q - DW'(1);
    end

    // Update the stack contents and the depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
            for (int i = 0; i < int'(DEPTH); i++) begin
                stk_q[i] <= '0;
            end
        end else begin
            if (push_eff) begin
                stk_q[base[IW-1:0]] <= push_prio;
            end
            depth_q <= base + DW'(push_eff);
        end
    end

    assign busy_o  = (depth_q != '0);
    assign top_o   = busy_o ? stk_q[top_idx[IW-1:0]] : '0;
    assign depth_o = depth_q;
endmodule

// File: rtl/intc_core.sv
// Interrupt controller top: register decode, per-line cells, enables,
// priority selection and the service stack. Assumes single-cycle bus
// accesses and N_SRC no larger than 32 (mode words fill 0x00..0x7C).
module intc_core
    import intc_pkg::*;
#(
    parameter int unsigned N_SRC  = 32,
    parameter int unsigned PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [7:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              irq_ack,
    output logic              irq
);
    localparam int unsigned SVC_DEPTH = 1 << PRIO_W;
    localparam int unsigned SVC_DW    = $clog2(SVC_DEPTH + 1);

    logic [4:0]              mode_idx;
    logic                    mode_hit;
    logic [N_SRC-1:0]        mode_we;
    logic [N_SRC-1:0]        req_clr;
    logic [N_SRC-1:0]        pend;
    logic [N_SRC-1:0]        en_q;
    logic [N_SRC-1:0]        line_edge, line_pol;
    logic [N_SRC*PRIO_W-1:0] prio_flat;
    logic [BUS_DW-1:0]       mode_word [N_SRC];
    logic                    any_cand;
    logic [PRIO_W-1:0]       best_prio, top_prio;
    logic                    svc_busy, svc_push, svc_pop;
    logic [SVC_DW-1:0]       svc_depth;

    // Decode which mode word the address points at.
    always_comb begin
        mode_idx = bus_addr[6:2];
        mode_hit = !bus_addr[7] && (bus_addr[1:0] == 2'b00);
    end

    genvar g;
    generate
        for (g = 0; g < int'(N_SRC); g++) begin : g_line
            // Per-line strobes from the bus write.
            assign mode_we[g] = bus_we && mode_hit && (mode_idx == 5'(g));
            assign req_clr[g] = bus_we && (bus_addr == A_REQ_CLR) && bus_wdata[g];

            intc_src_cell #(.PRIO_W(PRIO_W)) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .src_i   (src_i[g]),
                .mode_we (mode_we[g]),
                .wr_edge (bus_wdata[MB_EDGE]),
                .wr_pol  (bus_wdata[MB_POL]),
                .wr_prio (bus_wdata[PRIO_W-1:0]),
                .req_clr (req_clr[g]),
                .edge_o  (line_edge[g]),
                .pol_o   (line_pol[g]),
                .prio_o  (prio_flat[g*PRIO_W +: PRIO_W]),
                .pend_o  (pend[g])
            );

            // Mode word as seen on the bus.
            always_comb begin
                mode_word[g]          = '0;
                mode_word[g][MB_POL]  = line_pol[g];
                mode_word[g][MB_EDGE] = line_edge[g];
                mode_word[g][PRIO_W-1:0] = prio_flat[g*PRIO_W +: PRIO_W];
            end
        end
    endgenerate

    // Enable vector: write-one set and write-one clear commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (bus_we && bus_addr == A_EN_SET) begin
            en_q <= en_q | bus_wdata[N_SRC-1:0];
        end else if (bus_we && bus_addr == A_EN_CLR) begin
            en_q <= en_q & ~bus_wdata[N_SRC-1:0];
        end
    end

    intc_prio_sel #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_sel (
        .cand      (pend & en_q),
        .prio_flat (prio_flat),
        .any_o     (any_cand),
        .best_o    (best_prio)
    );

    // Raise the interrupt only above the priority currently in service.
    always_comb begin
        irq      = any_cand && (!svc_busy || (best_prio > top_prio));
        svc_push = irq_ack && irq;
        svc_pop  = bus_we && (bus_addr == A_EOI);
    end

    intc_svc_stack #(.PRIO_W(PRIO_W), .DEPTH(SVC_DEPTH), .DW(SVC_DW)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (svc_push),
        .push_prio (best_prio),
        .pop       (svc_pop),
        .busy_o    (svc_busy),
        .top_o     (top_prio),
        .depth_o   (svc_depth)
    );

    // Read mux: mode words, request status, enable status, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (mode_hit) begin
            if (int'(mode_idx) < int'(N_SRC)) begin
                bus_rdata = mode_word[mode_idx];
            end
        end else if (bus_addr == A_PEND) begin
            bus_rdata = BUS_DW'(pend);
        end else if (bus_addr == A_EN_STAT) begin
            bus_rdata = BUS_DW'(en_q);
        end
    end
endmodule

// File: rtl/intc_core_chk.sv
// Property checker for intc_core, attached by bind. Observes ports and the
// enable vector, request vector and service-stack depth.
module intc_core_chk
    import intc_pkg::*;
#(
    parameter int unsigned N_SRC = 32,
    parameter int unsigned DW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       bus_addr,
    input logic             bus_we,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             irq_ack,
    input logic             irq,
    input logic [N_SRC-1:0] en_q,
    input logic [N_SRC-1:0] pend,
    input logic [DW-1:0]    svc_depth
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q == '0 && svc_depth == '0 && !irq));

    a_r3_set_bits_on: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_EN_SET) |=>
        ((en_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

    a_r4_clear_bits_off: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_EN_CLR) |=>
        ((en_q & $past(bus_wdata[N_SRC-1:0])) == '0));

    a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((pend & en_q) != '0));

    a_r10_ack_pushes: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq && !(bus_we && bus_addr == A_EOI)) |=>
        (svc_depth == $past(svc_depth) + DW'(1)));

    a_r10_idle_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq && !(bus_we && bus_addr == A_EOI)) |=> $stable(svc_depth));

    a_r11_eoi_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_EOI && svc_depth != '0 && !(irq_ack && irq)) |=>
        (svc_depth == $past(svc_depth) - DW'(1)));

    a_r12_commands_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && (bus_addr == A_EN_SET || bus_addr == A_EN_CLR ||
                     bus_addr == A_REQ_CLR || bus_addr == A_EOI)) |-> (bus_rdata == '0));
endmodule

bind intc_core intc_core_chk #(.N_SRC(N_SRC), .DW(SVC_DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_ack   (irq_ack),
    .irq       (irq),
    .en_q      (en_q),
    .pend      (pend),
    .svc_depth (svc_depth)
);

// File: tb/sim_intc_core.sv
// Bench for intc_core: behavioural reference model compared every cycle,
// plus directed checks with hand-computed expectations.
module sim_intc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [7:0]  addr = 8'hFC;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack = 1'b0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    intc_core u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_ack(ack), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_s1, m_s2, m_s3, m_edge, m_pol, m_cap, m_en;
    int          m_prio [32];
    int          m_stk [$];

    function automatic bit m_pend(int i);
        return m_edge[i] ? m_cap[i] : (m_s2[i] == m_pol[i]);
    endfunction

    function automatic int m_best();
        int b = -1;
        for (int i = 0; i < 32; i++)
            if (m_en[i] && m_pend(i) && m_prio[i] > b) b = m_prio[i];
        return b;
    endfunction

    function automatic bit m_irq();
        int b = m_best();
        if (b < 0) return 0;
        return (m_stk.size() == 0) || (b > m_stk[$]);
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        logic [31:0] v = '0;
        if (a < 8'h80 && a[1:0] == 2'b00) begin
            v[6] = m_pol[a[6:2]];
            v[5] = m_edge[a[6:2]];
            v[2:0] = 3'(m_prio[a[6:2]]);
        end else if (a == 8'h8C) begin
            for (int i = 0; i < 32; i++) v[i] = m_pend(i);
        end else if (a == 8'h90) begin
            v = m_en;
        end
        return v;
    endfunction

    // Advance the model on each rising edge with the inputs driven before it.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_edge = '0; m_pol = '1;
            m_cap = '0; m_en = '0; m_stk.delete();
            for (int i = 0; i < 32; i++) m_prio[i] = 0;
        end else begin
            bit          irq_now;
            int          bp;
            logic [31:0] ncap, clr;
            irq_now = m_irq();
            bp = m_best();
            clr = (we && addr == 8'h88) ? wdata : '0;
            for (int i = 0; i < 32; i++) begin
                bit det;
                det = m_pol[i] ? (m_s2[i] && !m_s3[i]) : (!m_s2[i] && m_s3[i]);
                ncap[i] = m_edge[i] ? ((m_cap[i] && !clr[i]) || det) : 1'b0;
            end
            m_cap = ncap;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = src;
            if (we) begin
                if (addr < 8'h80 && addr[1:0] == 2'b00) begin
                    m_edge[addr[6:2]] = wdata[5];
                    m_pol[addr[6:2]]  = wdata[6];
                    m_prio[addr[6:2]] = int'(wdata[2:0]);
                end else if (addr == 8'h80) m_en = m_en | wdata;
                else if (addr == 8'h84) m_en = m_en & ~wdata;
                else if (addr == 8'h94 && m_stk.size() > 0) void'(m_stk.pop_back());
            end
            if (ack && irq_now) m_stk.push_back(bp);
        end
    end

    // Compare irq and read data with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (irq !== m_irq()) begin
                n_bad++;
                $display("FAIL R9 model irq: actual %0b expected %0b at %0t", irq, m_irq(), $time);
            end
            if (!we) begin
                logic [31:0] e;
                string rq;
                e = m_read(addr);
                rq = (addr < 8'h80) ? "R2" : (addr == 8'h8C) ? "R8" : (addr == 8'h90) ? "R3" : "R12";
                n_cmp++;
                if (rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s model read @%02h: actual %08h expected %08h", rq, addr, rdata, e);
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic cyc(int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        cyc();
        we = 1'b0; addr = 8'h8C;
    endtask

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", rq, act, exp);
        end
    endtask

    task automatic rd_chk(string rq, logic [7:0] a, logic [31:0] exp);
        addr = a;
        @(negedge clk);
        chk(rq, rdata, exp);
        cyc();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] lfsr;
        cyc(3);
        rst_n = 1'b1;
        cyc();

        // R1: reset state
        @(negedge clk); chk("R1 irq", {31'b0, irq}, 32'h0); cyc();
        rd_chk("R1 enables", 8'h90, 32'h0);
        rd_chk("R1 mode word", 8'h00, 32'h40);
        rd_chk("R1 mode word 31", 8'h7C, 32'h40);

        // R2: mode field layout and unused bits
        wr(8'h14, 32'hFFFF_FF67);
        rd_chk("R2 mode readback", 8'h14, 32'h67);
        wr(8'h14, 32'h0000_0040);

        // R3/R4: write-one set and clear of enables
        wr(8'h80, 32'h0000_00F0);
        wr(8'h80, 32'h0000_0003);
        rd_chk("R3 set merges", 8'h90, 32'h0000_00F3);
        wr(8'h84, 32'h0000_0011);
        rd_chk("R4 clear selected", 8'h90, 32'h0000_00E2);
        wr(8'h84, 32'hFFFF_FFFF);

        // R5: level line latency through two flops
        wr(8'h0C, 32'h0000_0042);
        addr = 8'h8C; src[3] = 1'b1;
        @(negedge clk);
        @(negedge clk); chk("R5 one edge, not yet", rdata & 32'h8, 32'h0);
        @(negedge clk); chk("R5 two edges, seen", rdata & 32'h8, 32'h8);
        cyc();

        // R6: rising capture persists; falling capture on another line
        wr(8'h24, 32'h0000_0063);
        src[10] = 1'b1;
        wr(8'h28, 32'h0000_0024);
        cyc(3);
        src[9] = 1'b1; cyc(); src[9] = 1'b0;
        cyc(2);
        @(negedge clk); chk("R6 rising captured", rdata & 32'h200, 32'h200); cyc();
        cyc(5);
        rd_chk("R6 capture held", 8'h8C, 32'h0000_0208);
        src[10] = 1'b0; cyc(3);
        rd_chk("R6 falling captured", 8'h8C, 32'h0000_0608);

        // R7: clear affects edge lines only
        wr(8'h88, 32'h0000_0408);
        rd_chk("R7 clear edge only", 8'h8C, 32'h0000_0208);

        // R8: request visible without enable; R9/R10/R11: nesting
        wr(8'h80, 32'h0000_0208);
        @(negedge clk); chk("R9 irq with enabled request", {31'b0, irq}, 32'h1); cyc();
        wr(8'h88, 32'h0000_0200);
        ack = 1'b1; cyc(); ack = 1'b0;
        @(negedge clk); chk("R10 masked at own priority", {31'b0, irq}, 32'h0); cyc();
        ack = 1'b1; cyc(); ack = 1'b0;
        src[9] = 1'b1; cyc(4); src[9] = 1'b0;
        @(negedge clk); chk("R9 higher priority breaks through", {31'b0, irq}, 32'h1); cyc();
        ack = 1'b1; cyc(); ack = 1'b0;
        @(negedge clk); chk("R10 second level masked", {31'b0, irq}, 32'h0); cyc();
        wr(8'h88, 32'h0000_0200);
        wr(8'h94, 32'h1234_5678);
        @(negedge clk); chk("R11 pop to lower level", {31'b0, irq}, 32'h0); cyc();
        wr(8'h94, 32'h0);
        @(negedge clk); chk("R11 stack empty again", {31'b0, irq}, 32'h1); cyc();
        wr(8'h94, 32'h0);
        wr(8'h94, 32'h0);

        // R12: command and unmapped addresses read zero
        rd_chk("R12 enable set word", 8'h80, 32'h0);
        rd_chk("R12 disable word", 8'h84, 32'h0);
        rd_chk("R12 clear word", 8'h88, 32'h0);
        rd_chk("R12 end-of-service word", 8'h94, 32'h0);
        rd_chk("R12 unmapped", 8'hFC, 32'h0);

        // Mixed pseudo-random phase checked by the model every cycle
        lfsr = 32'hACE1_2468;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            src[7:0] = lfsr[7:0] ^ src[7:0] & {8{lfsr[8]}};
            ack = lfsr[9] & lfsr[10];
            we = 1'b0;
            addr = lfsr[11] ? 8'h8C : {1'b0, lfsr[16:12], 2'b00};
            if (lfsr[20:17] == 4'h0) begin
                we = 1'b1; addr = {3'b0, lfsr[23:21], 2'b00};
                wdata = {25'b0, lfsr[24], lfsr[25], 2'b0, lfsr[28:26]};
            end else if (lfsr[20:17] == 4'h1) begin
                we = 1'b1; addr = 8'h80; wdata = {24'b0, lfsr[31:24]};
            end else if (lfsr[20:17] == 4'h2) begin
                we = 1'b1; addr = 8'h84; wdata = {24'b0, lfsr[27:20]};
            end else if (lfsr[20:17] == 4'h3) begin
                we = 1'b1; addr = 8'h88; wdata = {24'b0, lfsr[30:23]};
            end else if (lfsr[20:17] == 4'h4) begin
                we = 1'b1; addr = 8'h94; wdata = lfsr;
            end
            cyc();
        end
        we = 1'b0; ack = 1'b0; addr = 8'h8C;
        cyc(2);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule